// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits in a synchronous clock domain and runs an external asynchronous static RAM of 32K bytes. A host hands it one read or one write at a time over a valid/ready port. The block then drives the memory's active-low select, write and output strobes, a 15-bit address and a split data bus: an output value, an output-enable and an input value that the pad ring merges into one tristate bus. Every phase of an access lasts a whole number of clock cycles. Each count is derived from a minimum or maximum time in nanoseconds and the clock period, with defaults for a 55 ns memory.

Between accesses the block waits in a quiet standby with all strobes high. A retention request input parks it in a low-power state with select held high. After the request is withdrawn, the block waits one read-cycle time before it accepts new work.

Back-pressure rules for the host port:
- `req_ready` is high only while the sequencer is idle and no retention is requested.
- A request is taken on a clock edge that sees `req_valid` and `req_ready` both high.
- Address, direction and write data are captured at that edge, so they may change afterwards.
- A host that sees `req_ready` low keeps `req_valid` and its fields until the handshake completes.
- Read data comes back as a one-cycle `rsp_valid` pulse. That pulse has no back-pressure.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, and right after it, select, write and output strobes are high, the data-bus drive is off, address and write data are zero, `rsp_valid` is low and `req_ready` is high when retention is not requested.
- R2: `req_ready` is high exactly when the sequencer is idle and `retain_req` is low. During `req_ready` all three strobes are high and the data bus is not driven. A request is accepted only on an edge where `req_valid` and `req_ready` are both high.
- R3: A read (`req_write` = 0) holds select low, output enable low and write enable high for RD_CYC cycles (7 at defaults: ceil(55/8)), starting the cycle after acceptance, with the accepted address on `sram_addr`.
- R4: In the cycle after the read window, `rsp_valid` is high for exactly one cycle. `rsp_rdata` then holds `sram_dq_in` as sampled at the last edge of the window, and it keeps that value until the next read.
- R5: After a read, all strobes stay high for TA_CYC cycles (3 at defaults: ceil(20/8)) before `req_ready` returns. The data bus is never driven while output enable is low, and never before output enable has been high for TA_CYC cycles.
- R6: A write (`req_write` = 1) first spends SU_CYC cycles (1) with select low, write enable high and the data bus driven. It then spends WP_CYC cycles (6) with write enable low as well. The data reaches the addressed location, and a later read returns it.
- R7: During a write, output enable stays high. Write enable is never low unless select is low, and select falls no later than write enable, so the memory's outputs stay high-impedance.
- R8: The data bus stays driven for REC_CYC cycles (1) after write enable rises, and is released when the sequencer returns to idle. Address and write data stay constant for as long as select remains low.
- R9: When `retain_req` is seen in idle, the sequencer enters retention: all strobes high, `req_ready` low. After `retain_req` falls, it waits RT_CYC cycles (7: one read cycle of 55 ns) before `req_ready` rises again. Raising `retain_req` again restarts that wait.
- R10: Each phase length is ceil(time / CLK_NS) with a floor of 1. The write-pulse phase is also stretched to cover select-to-end (50 ns), address-to-end (50 ns) and data setup (25 ns). Recovery is stretched to fill the write cycle (55 ns).
- R11: A `retain_req` present in idle wins over a simultaneous `req_valid`. A `retain_req` raised during an access does not cut it short; retention begins once the access has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retain_req | input | 1 | Request to enter the low-power retention state |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address of the request |
| req_wdata | input | 8 | Data for a write |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 8 | Data of the last read |
| sram_cs_n | output | 1 | Memory select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 15 | Memory address |
| sram_dq_out | output | 8 | Value to drive on the data bus |
| sram_dq_oe | output | 1 | Data-bus drive enable for the pad |
| sram_dq_in | input | 8 | Value seen on the data bus |

## Verification
All pins are registered from the sequencer's next state. Because of that, every strobe, the address, the data-bus drive and `rsp_valid` change on the same edge at which the phase changes. The bench therefore compares each output against its reference model at the falling edge that follows each rising edge. A read's strobes are due one cycle after the accepting edge and last RD_CYC cycles. Its response pulse is due in the cycle right after that window, and `req_ready` returns TA_CYC cycles after the pulse. A write's drive and strobes follow the same one-edge rule through setup, pulse and recovery. Inputs are changed 2 ns after a rising edge, so the model always sees the values the design sampled.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_OPEN,
    SQ_RD_QUIET,
    SQ_WR_ARM,
    SQ_WR_STROBE,
    SQ_WR_HOLD,
    SQ_PARK
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } pin_ctl_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Minimum time in ns to whole clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    return imax(1, (t_ns + clk_ns - 1) / clk_ns);
  endfunction

  function automatic pin_ctl_t pins_of(input seq_state_e s);
    pin_ctl_t p;
    p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    case (s)
      SQ_RD_OPEN:   begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
      SQ_WR_ARM:    begin p.cs_n = 1'b0; p.drive = 1'b1; end
      SQ_WR_STROBE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
      SQ_WR_HOLD:   begin p.cs_n = 1'b0; p.drive = 1'b1; end
      default:      p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_CYC  = 7,
  parameter int TA_CYC  = 3,
  parameter int SU_CYC  = 1,
  parameter int WP_CYC  = 6,
  parameter int REC_CYC = 1,
  parameter int RT_CYC  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retain_req,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             done,
  output seq_state_e       nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             ready,
  output logic             rsp_fire
);
  seq_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= nxt;
  end

  assign ready    = (st_q == SQ_IDLE) && !retain_req;
  assign accept   = ready && req_valid;
  assign rsp_fire = (st_q == SQ_RD_OPEN) && done;

  always_comb begin
    nxt = st_q;
    case (st_q)
      SQ_IDLE:      if (retain_req) nxt = SQ_PARK;
                    else if (req_valid) nxt = req_write ? SQ_WR_ARM : SQ_RD_OPEN;
      SQ_RD_OPEN:   if (done) nxt = SQ_RD_QUIET;
      SQ_RD_QUIET:  if (done) nxt = SQ_IDLE;
      SQ_WR_ARM:    if (done) nxt = SQ_WR_STROBE;
      SQ_WR_STROBE: if (done) nxt = SQ_WR_HOLD;
      SQ_WR_HOLD:   if (done) nxt = SQ_IDLE;
      SQ_PARK:      if (!retain_req && done) nxt = SQ_IDLE;
      default:      nxt = SQ_IDLE;
    endcase
  end

  assign load = (nxt != st_q) || ((st_q == SQ_PARK) && retain_req);

  always_comb begin
    case (nxt)
      SQ_RD_OPEN:   load_val = CNT_W'(RD_CYC - 1);
      SQ_RD_QUIET:  load_val = CNT_W'(TA_CYC - 1);
      SQ_WR_ARM:    load_val = CNT_W'(SU_CYC - 1);
      SQ_WR_STROBE: load_val = CNT_W'(WP_CYC - 1);
      SQ_WR_HOLD:   load_val = CNT_W'(REC_CYC - 1);
      SQ_PARK:      load_val = CNT_W'(RT_CYC - 1);
      default:      load_val = '0;
    endcase
  end
endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        nxt,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_fire,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_dq_oe,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  pin_ctl_t ctl_d;
  assign ctl_d = pins_of(nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_cs_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
    end else begin
      sram_cs_n  <= ctl_d.cs_n;
      sram_we_n  <= ctl_d.we_n;
      sram_oe_n  <= ctl_d.oe_n;
      sram_dq_oe <= ctl_d.drive;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else if (accept) begin
      sram_addr   <= req_addr;
      sram_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_fire;
      if (rsp_fire) rsp_rdata <= sram_dq_in;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 8,
  parameter int T_ACC  = 55,
  parameter int T_HIZ  = 20,
  parameter int T_ASU  = 0,
  parameter int T_WPW  = 40,
  parameter int T_SEL  = 50,
  parameter int T_AVE  = 50,
  parameter int T_DSU  = 25,
  parameter int T_WREC = 0,
  parameter int T_WCYC = 55,
  parameter int T_RCYC = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retain_req,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int RD_CYC  = ns_to_cyc(T_ACC, CLK_NS);
  localparam int TA_CYC  = ns_to_cyc(T_HIZ, CLK_NS);
  localparam int SU_CYC  = ns_to_cyc(T_ASU, CLK_NS);
  localparam int WP_CYC  = imax(imax(ns_to_cyc(T_WPW, CLK_NS), ns_to_cyc(T_DSU, CLK_NS)),
                                imax(ns_to_cyc(T_SEL, CLK_NS), ns_to_cyc(T_AVE, CLK_NS)) - SU_CYC);
  localparam int REC_CYC = imax(ns_to_cyc(T_WREC, CLK_NS),
                                ns_to_cyc(T_WCYC, CLK_NS) - SU_CYC - WP_CYC);
  localparam int RT_CYC  = ns_to_cyc(T_RCYC, CLK_NS);
  localparam int MAX_CYC = imax(imax(imax(RD_CYC, TA_CYC), imax(SU_CYC, WP_CYC)),
                                imax(REC_CYC, RT_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e       nxt;
  logic             load, done, accept, rsp_fire;
  logic [CNT_W-1:0] load_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .done(done)
  );

  sram_seq_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC), .SU_CYC(SU_CYC),
    .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .RT_CYC(RT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .retain_req(retain_req), .req_valid(req_valid),
    .req_write(req_write), .done(done), .nxt(nxt), .load(load),
    .load_val(load_val), .accept(accept), .ready(req_ready), .rsp_fire(rsp_fire)
  );

  sram_pin_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .accept(accept),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_fire(rsp_fire),
    .sram_dq_in(sram_dq_in), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_oe(sram_dq_oe), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int TA_CYC = 3,
  parameter int WP_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_out
);
  localparam int QW = $clog2(TA_CYC + 2);
  localparam int LW = $clog2(WP_CYC + 2);

  logic [QW-1:0] quiet_q;
  logic [LW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       quiet_q <= QW'(TA_CYC);
    else if (!sram_oe_n)              quiet_q <= '0;
    else if (quiet_q < QW'(TA_CYC))   quiet_q <= quiet_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       low_q <= '0;
    else if (sram_we_n)               low_q <= '0;
    else if (low_q < LW'(WP_CYC))     low_q <= low_q + 1'b1;
  end

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R2
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R5
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (quiet_q >= QW'(TA_CYC))); // R5
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (low_q >= LW'(WP_CYC))); // R6
  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n); // R7
  AST_WE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(!sram_cs_n)); // R7
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R8
endmodule

bind sram_async_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TA_CYC(TA_CYC), .WP_CYC(WP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
  .sram_dq_oe(sram_dq_oe), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out)
);

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;
  localparam int CLK = 8;
  function automatic int cy(input int t);
    int c;
    c = (t + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int RD  = cy(55);
  localparam int TA  = cy(20);
  localparam int SU  = cy(0);
  localparam int WPA = (cy(40) > cy(25)) ? cy(40) : cy(25);
  localparam int WPB = cy(50) - SU;
  localparam int WP  = (WPA > WPB) ? WPA : WPB;
  localparam int RCA = cy(55) - SU - WP;
  localparam int REC = (RCA > 1) ? RCA : 1;
  localparam int RT  = cy(55);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retain_req = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [14:0] sram_addr;

  logic [7:0] smem [0:32767];
  logic [7:0] refm [0:32767];

  int n_chk = 0, n_fail = 0;

  always #(CLK/2) clk = ~clk;

  sram_async_ctrl uut (
    .clk(clk), .rst_n(rst_n), .retain_req(retain_req), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  // Behavioural memory: drives data only in read mode, stores at the end of a write.
  assign sram_dq_in = (!sram_cs_n && sram_we_n && !sram_oe_n) ? smem[sram_addr] : 8'h00;
  always @(posedge sram_we_n) if (rst_n && !sram_cs_n) smem[sram_addr] = sram_dq_out;

  // Reference model: 0 idle, 1 read, 2 read quiet, 3 write setup, 4 write pulse, 5 write hold, 6 retention
  int m_st = 0, m_left = 0;
  logic [14:0] m_addr = '0;
  logic [7:0]  m_wd = '0, m_rd = '0;
  logic        m_rsp = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_addr = '0; m_wd = '0; m_rd = '0; m_rsp = 1'b0;
    end else begin
      m_rsp = 1'b0;
      case (m_st)
        0: if (retain_req) begin m_st = 6; m_left = RT - 1; end
           else if (req_valid) begin
             m_addr = req_addr; m_wd = req_wdata;
             if (req_write) begin refm[req_addr] = req_wdata; m_st = 3; m_left = SU - 1; end
             else begin m_st = 1; m_left = RD - 1; end
           end
        1: if (m_left == 0) begin m_rsp = 1'b1; m_rd = refm[m_addr]; m_st = 2; m_left = TA - 1; end
           else m_left--;
        2: if (m_left == 0) m_st = 0; else m_left--;
        3: if (m_left == 0) begin m_st = 4; m_left = WP - 1; end else m_left--;
        4: if (m_left == 0) begin m_st = 5; m_left = REC - 1; end else m_left--;
        5: if (m_left == 0) m_st = 0; else m_left--;
        6: if (retain_req) m_left = RT - 1;
           else if (m_left == 0) m_st = 0;
           else m_left--;
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int s);
    case (s)
      0: return "R1 R2";
      1: return "R3 R10";
      2: return "R5";
      3: return "R6 R10";
      4: return "R6 R7";
      5: return "R8";
      default: return "R9 R11";
    endcase
  endfunction

  always @(negedge clk) begin
    string tg;
    tg = tag_of(m_st);
    chk(tg, "cs_n", 32'(sram_cs_n), 32'(!(m_st == 1 || m_st == 3 || m_st == 4 || m_st == 5)));
    chk(tg, "we_n", 32'(sram_we_n), 32'(m_st != 4));
    chk(tg, "oe_n", 32'(sram_oe_n), 32'(m_st != 1));
    chk(tg, "dq_oe", 32'(sram_dq_oe), 32'(m_st == 3 || m_st == 4 || m_st == 5));
    chk(tg, "addr", 32'(sram_addr), 32'(m_addr));
    chk(tg, "dq_out", 32'(sram_dq_out), 32'(m_wd));
    chk("R2", "req_ready", 32'(req_ready), 32'(m_st == 0 && !retain_req));
    chk("R4", "rsp_valid", 32'(rsp_valid), 32'(m_rsp));
    chk("R4", "rsp_rdata", 32'(rsp_rdata), 32'(m_rd));
  end

  task automatic issue(input logic wr, input logic [14:0] a, input logic [7:0] d);
    logic acc;
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk);
    end while (!acc);
    #2 req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 32768; i++) begin
      smem[i] = 8'(i * 7 + 3);
      refm[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(3);
    // R3 R4: reads of the pre-loaded pattern, including the top address
    issue(1'b0, 15'h0010, 8'h00);
    issue(1'b0, 15'h7FFF, 8'h00);
    idle(12);
    // R6 R7 R8: writes at the ends of the range, then read back
    issue(1'b1, 15'h0123, 8'h5A);
    issue(1'b1, 15'h7FFF, 8'hFF);
    issue(1'b1, 15'h0000, 8'h00);
    issue(1'b0, 15'h0123, 8'h00);
    issue(1'b0, 15'h7FFF, 8'h00);
    issue(1'b0, 15'h0000, 8'h00);
    // R5: read directly followed by write, then write directly followed by read
    issue(1'b0, 15'h0040, 8'h00);
    issue(1'b1, 15'h0040, 8'hC3);
    issue(1'b0, 15'h0040, 8'h00);
    idle(12);
    // R9 R11: retention wins over a waiting request, wait restarts on re-raise
    @(posedge clk); #2;
    retain_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h0123;
    idle(10); #2 retain_req = 1'b0;
    idle(3);  #2 retain_req = 1'b1;
    idle(2);  #2 retain_req = 1'b0;
    begin
      logic acc;
      do begin
        @(negedge clk); acc = req_ready;
        @(posedge clk);
      end while (!acc);
      #2 req_valid = 1'b0;
    end
    // R11: retention raised mid-access does not cut the write short
    issue(1'b1, 15'h0200, 8'h77);
    #2 retain_req = 1'b1;
    idle(20); #2 retain_req = 1'b0;
    issue(1'b0, 15'h0200, 8'h00);
    // mixed traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[0], {12'h000, lfsr[3:1]} | (lfsr[4] ? 15'h7FF8 : 15'h0000), lfsr[15:8]);
      if (lfsr[5]) idle(int'(lfsr[7:6]));
    end
    idle(20);
    summary();
    $finish;
  end
endmodule